// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a shared two-port memory and watches the select and address lines of both ports. When both ports are enabled and point at the same word, it decides which port keeps access and raises a busy flag toward the other one. It also removes that port's write strobe so that the word cannot be corrupted. The decision looks only at enables and addresses. Whether either side is reading or writing has no influence on who wins.

The block has two modes, chosen by `masterMode`. In master mode it arbitrates and drives the busy outputs. In slave mode its busy outputs stay low, and the per-port busy inputs act only as write blocks. This lets several blocks that serve a wider word follow one arbitrating instance. All inputs are sampled on one clock. The order of arrival is judged by which port's registered enable/address changed in the cycle the collision first appears.

Top module: `dual_port_busy_arbiter`

## Requirements
- R1: After reset, both busy outputs are low, and the arbiter holds no ownership until a collision is seen.
- R2: If either port is disabled, or the two registered addresses differ in any of the 16 bits, both busy outputs are low.
- R3: In master mode, when a match begins because only one port's enable/address changed, the port that did not change wins, and the port that changed gets busy. The read/write requests play no part in this choice.
- R4: When both ports change in the same cycle and the result is a match, the left port wins and `rightBusyOut` rises.
- R5: `leftBusyOut` and `rightBusyOut` are never high together.
- R6: A busy flag stays high while the match persists, until the winning port changes its address or drops its enable. The flag falls at the same point in the pipeline at which it would have risen.
- R7: In master mode, `leftWrEn` = `leftEn` & `leftWrReq` & !`leftBusyOut`, and the same rule holds on the right. The busy input pins have no effect in this mode.
- R8: In slave mode, both busy outputs are low, and a port's write enable is its request gated by that port's busy input. A busy input held high blocks that port's writes for as long as it is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1 = arbitrate and drive busy, 0 = busy pins are write blocks |
| leftEn | input | 1 | Left port select |
| leftAddr | input | ADDR_W (16) | Left port word address |
| leftWrReq | input | 1 | Left port write request |
| leftBusyIn | input | 1 | Left write block (slave mode only) |
| rightEn | input | 1 | Right port select |
| rightAddr | input | ADDR_W (16) | Right port word address |
| rightWrReq | input | 1 | Right port write request |
| rightBusyIn | input | 1 | Right write block (slave mode only) |
| leftBusyOut | output | 1 | Left port lost arbitration |
| rightBusyOut | output | 1 | Right port lost arbitration |
| leftWrEn | output | 1 | Gated left write strobe |
| rightWrEn | output | 1 | Gated right write strobe |

## Verification
A change on the enables or addresses reaches the busy outputs after the second rising edge: one edge registers the inputs, and the next updates the ownership state. The write enables respond in the same cycle to the request, the mode and the busy inputs, combined with whatever ownership is currently held. The bench drives on falling edges and keeps a cycle model with the same two-stage timing. It compares every output one half-cycle after each rising edge, so both the two-edge busy latency and the immediate gating are checked at the exact cycle in which they are due.

// File: rtl/dpbusy_pkg.sv
package dpbusy_pkg;

  typedef enum logic [1:0] {
    ARB_IDLE       = 2'd0,
    ARB_LEFT_OWNS  = 2'd1,
    ARB_RIGHT_OWNS = 2'd2
  } arbState_t;

  // datapath -> control
  typedef struct packed {
    logic addrMatch;
    logic leftMoved;
    logic rightMoved;
  } dpStatus_t;

  // control -> datapath
  typedef struct packed {
    logic leftBlock;
    logic rightBlock;
  } ctrlStrobe_t;

endpackage

// File: rtl/dpbusy_port_track.sv
module dpbusy_port_track #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              enQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              moved
);
  localparam int TAG_W = ADDR_W + 1;

  logic [TAG_W-1:0] curTag;
  logic [TAG_W-1:0] prevTag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curTag  <= '0;
      prevTag <= '0;
    end else begin
      curTag  <= {en, addr};
      prevTag <= curTag;
    end
  end

  assign enQ   = curTag[TAG_W-1];
  assign addrQ = curTag[ADDR_W-1:0];
  assign moved = (curTag != prevTag);
endmodule

// File: rtl/dpbusy_datapath.sv
module dpbusy_datapath
  import dpbusy_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  masterMode,
  input  logic [1:0]            portEn,
  input  logic [2*ADDR_W-1:0]   portAddr,
  input  logic [1:0]            portWrReq,
  input  logic [1:0]            busyIn,
  input  ctrlStrobe_t           strobe,
  output dpStatus_t             status,
  output logic [1:0]            busyOut,
  output logic [1:0]            wrEn
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]        enQ;
  logic [NPORT-1:0]        moved;
  logic [NPORT*ADDR_W-1:0] addrQ;
  logic [NPORT-1:0]        blockInt;
  logic [NPORT-1:0]        blockEff;

  assign blockInt = {strobe.rightBlock, strobe.leftBlock};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpbusy_port_track #(.ADDR_W(ADDR_W)) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (portEn[p]),
      .addr  (portAddr[p*ADDR_W +: ADDR_W]),
      .enQ   (enQ[p]),
      .addrQ (addrQ[p*ADDR_W +: ADDR_W]),
      .moved (moved[p])
    );

    always_comb begin
      blockEff[p] = masterMode ? blockInt[p] : busyIn[p];
      wrEn[p]     = portEn[p] & portWrReq[p] & ~blockEff[p];
      busyOut[p]  = masterMode & blockInt[p];
    end
  end

  always_comb begin
    status.addrMatch  = enQ[0] & enQ[1] &
                        (addrQ[0 +: ADDR_W] == addrQ[ADDR_W +: ADDR_W]);
    status.leftMoved  = moved[0];
    status.rightMoved = moved[1];
  end
endmodule

// File: rtl/dpbusy_control.sv
module dpbusy_control
  import dpbusy_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ARB_IDLE: begin
        if (status.addrMatch) begin
          if (status.leftMoved && !status.rightMoved)
            stateNext = ARB_RIGHT_OWNS;
          else
            stateNext = ARB_LEFT_OWNS;   // right moved last, tie, or static
        end
      end
      ARB_LEFT_OWNS: begin
        if (!status.addrMatch || status.leftMoved) stateNext = ARB_IDLE;
      end
      ARB_RIGHT_OWNS: begin
        if (!status.addrMatch || status.rightMoved) stateNext = ARB_IDLE;
      end
      default: stateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ARB_IDLE;
    else        state <= stateNext;
  end

  assign strobe.leftBlock  = (state == ARB_RIGHT_OWNS);
  assign strobe.rightBlock = (state == ARB_LEFT_OWNS);
endmodule

// File: rtl/dual_port_busy_arbiter.sv
module dual_port_busy_arbiter
  import dpbusy_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterMode,
  input  logic              leftEn,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              leftWrReq,
  input  logic              leftBusyIn,
  input  logic              rightEn,
  input  logic [ADDR_W-1:0] rightAddr,
  input  logic              rightWrReq,
  input  logic              rightBusyIn,
  output logic              leftBusyOut,
  output logic              rightBusyOut,
  output logic              leftWrEn,
  output logic              rightWrEn
);
  dpStatus_t   status;
  ctrlStrobe_t strobe;
  logic [1:0]  busyOutVec;
  logic [1:0]  wrEnVec;

  dpbusy_datapath #(.ADDR_W(ADDR_W)) u_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .masterMode (masterMode),
    .portEn     ({rightEn, leftEn}),
    .portAddr   ({rightAddr, leftAddr}),
    .portWrReq  ({rightWrReq, leftWrReq}),
    .busyIn     ({rightBusyIn, leftBusyIn}),
    .strobe     (strobe),
    .status     (status),
    .busyOut    (busyOutVec),
    .wrEn       (wrEnVec)
  );

  dpbusy_control u_control (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status),
    .strobe (strobe)
  );

  assign leftBusyOut  = busyOutVec[0];
  assign rightBusyOut = busyOutVec[1];
  assign leftWrEn     = wrEnVec[0];
  assign rightWrEn    = wrEnVec[1];
endmodule

// File: rtl/dpbusy_checks.sv
module dpbusy_checks #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              masterMode,
  input logic              leftEn,
  input logic [ADDR_W-1:0] leftAddr,
  input logic              leftWrReq,
  input logic              leftBusyIn,
  input logic              rightEn,
  input logic [ADDR_W-1:0] rightAddr,
  input logic              rightWrReq,
  input logic              rightBusyIn,
  input logic              leftBusyOut,
  input logic              rightBusyOut,
  input logic              leftWrEn,
  input logic              rightWrEn
);
  AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(leftBusyOut && rightBusyOut)); // R5

  AST_NO_MATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(leftEn, 2) || !$past(rightEn, 2) || ($past(leftAddr, 2) != $past(rightAddr, 2)))
      |-> (!leftBusyOut && !rightBusyOut)); // R2

  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !masterMode |-> (!leftBusyOut && !rightBusyOut)); // R8

  AST_SLAVE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!masterMode && (leftBusyIn || rightBusyIn))
      |-> (!(leftBusyIn && leftWrEn) && !(rightBusyIn && rightWrEn))); // R8

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    masterMode |-> (!(leftBusyOut && leftWrEn) && !(rightBusyOut && rightWrEn))); // R7

  AST_WR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (leftWrEn || rightWrEn)
      |-> ((!leftWrEn || (leftEn && leftWrReq)) && (!rightWrEn || (rightEn && rightWrReq)))); // R7
endmodule

bind dual_port_busy_arbiter dpbusy_checks #(.ADDR_W(ADDR_W)) u_dpbusy_checks (.*);

// File: tb/dual_port_busy_arbiter_bench.sv
`timescale 1ns/1ps
module dual_port_busy_arbiter_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic masterMode = 1'b1;
  logic leftEn = 1'b0, rightEn = 1'b0;
  logic [AW-1:0] leftAddr = '0, rightAddr = '0;
  logic leftWrReq = 1'b0, rightWrReq = 1'b0;
  logic leftBusyIn = 1'b0, rightBusyIn = 1'b0;
  logic leftBusyOut, rightBusyOut, leftWrEn, rightWrEn;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // cycle model: two-stage input tags and ownership (0 idle, 1 left owns, 2 right owns)
  logic [AW:0] mS1L = '0, mS2L = '0, mS1R = '0, mS2R = '0;
  int mState = 0;

  always #5 clk = ~clk;

  dual_port_busy_arbiter #(.ADDR_W(AW)) u_dual_port_busy_arbiter (
    .clk(clk), .rst_n(rst_n), .masterMode(masterMode),
    .leftEn(leftEn), .leftAddr(leftAddr), .leftWrReq(leftWrReq), .leftBusyIn(leftBusyIn),
    .rightEn(rightEn), .rightAddr(rightAddr), .rightWrReq(rightWrReq), .rightBusyIn(rightBusyIn),
    .leftBusyOut(leftBusyOut), .rightBusyOut(rightBusyOut),
    .leftWrEn(leftWrEn), .rightWrEn(rightWrEn)
  );

  function automatic int nextOwner(logic [AW:0] s1L, logic [AW:0] s2L,
                                   logic [AW:0] s1R, logic [AW:0] s2R, int cur);
    bit match = s1L[AW] && s1R[AW] && (s1L[AW-1:0] == s1R[AW-1:0]);
    bit chgL = (s1L != s2L);
    bit chgR = (s1R != s2R);
    case (cur)
      0: if (match) return (chgL && !chgR) ? 2 : 1;
      1: if (!match || chgL) return 0;
      2: if (!match || chgR) return 0;
      default: return 0;
    endcase
    return cur;
  endfunction

  function automatic logic [3:0] expected();
    logic lb = masterMode && (mState == 2);
    logic rb = masterMode && (mState == 1);
    logic blkL = masterMode ? (mState == 2) : leftBusyIn;
    logic blkR = masterMode ? (mState == 1) : rightBusyIn;
    return {lb, rb, leftEn & leftWrReq & ~blkL, rightEn & rightWrReq & ~blkR};
  endfunction

  task automatic compare(string tag);
    logic [3:0] act = {leftBusyOut, rightBusyOut, leftWrEn, rightWrEn};
    logic [3:0] exp = expected();
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {lbusy,rbusy,lwr,rwr} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    mState = nextOwner(mS1L, mS2L, mS1R, mS2R, mState);
    mS2L = mS1L; mS1L = {leftEn, leftAddr};
    mS2R = mS1R; mS1R = {rightEn, rightAddr};
    @(negedge clk);
    compare(tag);
  endtask

  task automatic drive(logic le, logic [AW-1:0] la, logic lw,
                       logic re, logic [AW-1:0] ra, logic rw);
    leftEn = le; leftAddr = la; leftWrReq = lw;
    rightEn = re; rightAddr = ra; rightWrReq = rw;
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1 reset state");
    tick("R1 idle after reset");

    // R2: both enabled, different addresses
    drive(1, 16'h1234, 1, 1, 16'h1235, 1);
    repeat (3) tick("R2 mismatch keeps busy low");
    if (leftBusyOut || rightBusyOut) begin bad++; $display("FAIL R2 busy=%b%b expected=00", leftBusyOut, rightBusyOut); end
    total++;

    // R3: left settled, right arrives later with a write -> right busy, write gated (R7)
    drive(1, 16'hFFFF, 0, 0, 16'h0000, 0);
    repeat (2) tick("R3 left settles");
    drive(1, 16'hFFFF, 1, 1, 16'hFFFF, 1);
    tick("R3 right arrives");
    tick("R3 busy after two edges");
    total++;
    if (!(rightBusyOut && !leftBusyOut && !rightWrEn && leftWrEn)) begin
      bad++; $display("FAIL R3 act=%b%b%b%b expected=0110", leftBusyOut, rightBusyOut, leftWrEn, rightWrEn);
    end
    // R6: busy held, then released after winner moves
    repeat (4) tick("R6 busy held");
    drive(1, 16'hFFFE, 1, 1, 16'hFFFF, 1);
    repeat (3) tick("R6 release after winner moves");
    total++;
    if (rightBusyOut || leftBusyOut) begin bad++; $display("FAIL R6 busy=%b%b expected=00", leftBusyOut, rightBusyOut); end

    // R3 mirrored: right settled, left arrives with read only
    drive(0, 16'h0000, 0, 1, 16'h00A5, 0);
    repeat (3) tick("R3 right settles");
    drive(1, 16'h00A5, 0, 1, 16'h00A5, 1);
    repeat (2) tick("R3 left late gets busy");
    total++;
    if (!(leftBusyOut && !rightBusyOut && rightWrEn)) begin bad++; $display("FAIL R3 mirror act=%b%b expected=10", leftBusyOut, rightBusyOut); end
    // R6: winner drops enable
    drive(1, 16'h00A5, 0, 0, 16'h00A5, 0);
    repeat (2) tick("R6 winner deselect releases");

    // R4: both move to same address in one cycle
    drive(0, 16'h0000, 0, 0, 16'h0001, 0);
    repeat (3) tick("R4 idle");
    drive(1, 16'h4242, 1, 1, 16'h4242, 1);
    repeat (2) tick("R4 tie goes to left");
    total++;
    if (!(rightBusyOut && !leftBusyOut && leftWrEn && !rightWrEn)) begin bad++; $display("FAIL R4 act=%b%b%b%b expected=0110", leftBusyOut, rightBusyOut, leftWrEn, rightWrEn); end

    // R7: busy input pins ignored in master mode
    drive(1, 16'h0010, 1, 1, 16'h0020, 1);
    leftBusyIn = 1; rightBusyIn = 1;
    repeat (3) tick("R7 busy pins ignored in master");
    total++;
    if (!(leftWrEn && rightWrEn)) begin bad++; $display("FAIL R7 wr=%b%b expected=11", leftWrEn, rightWrEn); end

    // R8: slave mode
    masterMode = 0; leftBusyIn = 1; rightBusyIn = 0;
    drive(1, 16'h7777, 1, 1, 16'h7777, 1);
    repeat (6) tick("R8 slave held block");
    total++;
    if (leftWrEn || !rightWrEn || leftBusyOut || rightBusyOut) begin
      bad++; $display("FAIL R8 act=%b%b%b%b expected=0001", leftBusyOut, rightBusyOut, leftWrEn, rightWrEn);
    end
    leftBusyIn = 0; rightBusyIn = 0; masterMode = 1;
    tick("R8 back to master");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] pool [4] = '{16'h1234, 16'hFFFF, 16'h0000, 16'h1235};
      if (i % 250 == 0) masterMode = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 3) == 0) leftAddr = pool[$urandom_range(0, 3)];
      if ($urandom_range(0, 3) == 0) rightAddr = pool[$urandom_range(0, 3)];
      if ($urandom_range(0, 9) == 0) leftEn = ~leftEn;
      if ($urandom_range(0, 9) == 0) rightEn = ~rightEn;
      leftWrReq = $urandom_range(0, 1); rightWrReq = $urandom_range(0, 1);
      leftBusyIn = $urandom_range(0, 1); rightBusyIn = $urandom_range(0, 1);
      tick("R2 R3 R6 R7 R8 random");
      total++;
      if (leftBusyOut && rightBusyOut) begin bad++; $display("FAIL R5 busy=11 expected not both"); end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule